// File: doc/BRIEF.md
# Timekeeper NVRAM Register File

This block is a byte-wide non-volatile style memory with a sixteen-byte register page at the very top of its address space. The page holds the alarm fields, an interrupt enable byte, a watchdog byte and a read-only flags byte. Software reaches the storage in two ways. A direct bus moves one, two or four bytes per request and splits wider requests into byte operations, most significant byte first. An indirect window of four byte offsets first builds an address from two byte writes and then moves data through a third offset. Every byte operation, whatever its path, passes the same lock and register checks.

The `FULL_MODEL` parameter picks the variant. With it set, writes to the alarm fields are kept only when their masked BCD content is in range, the flags byte ignores writes, a watchdog write sends out a reload strobe, and an alarm pulse fires when the stored alarm fields equal the time supplied on the time inputs. With it clear, the whole top page is plain storage. Two lock inputs hide two sixteen-byte windows in the low array. Time counting, the watchdog countdown and data retention are outside this block. When the direct bus is mid-transfer it owns the storage, and the window reads back all ones and drops its data writes.

Top module: `tk_nvram`

## Requirements
- R1: A read of an address outside the storage (at or above `LOW_BYTES` and below the top page 0x1FF0..0x1FFF, or with address bits set above `ADDR_W`) returns 0xFF, and a write there changes nothing.
- R2: With `lock_i[0]` high, bytes 0x20..0x2F read as 0xFF and ignore writes; with `lock_i[1]` high, bytes 0x30..0x3F do the same. Unlocked bytes keep their contents across locking.
- R3: In the full model the flags byte at 0x1FF0 ignores writes and keeps its reset value of zero.
- R4: In the full model a write to alarm seconds (0x1FF2) or alarm minutes (0x1FF3) is kept, unmasked, only when the value ANDed with 0x7F has both nibbles at most 9 and a decimal value of 0 to 59; otherwise the old byte stays.
- R5: In the full model a write to alarm hours (0x1FF4) is kept only when the value ANDed with 0x3F is valid BCD with a decimal value of 0 to 23.
- R6: In the full model a write to alarm date (0x1FF5) is kept only when the value ANDed with 0x1F is valid BCD and not zero.
- R7: The interrupt enable byte (0x1FF6) and watchdog byte (0x1FF7) keep whatever is written; in the full model a watchdog write raises `wd_load` for one cycle, with `wd_value` equal to the written byte, in the cycle after the write.
- R8: In the basic model every byte of 0x1FF0..0x1FF7 stores and returns any value, and `wd_load` and `alarm_hit` stay low.
- R9: In the window, a write at offset 0 loads the low address byte, at offset 1 the high address byte, and at offset 3 writes the data byte at the built address and clears the address to zero; offset 2 writes do nothing. A read at offset 3 returns the addressed byte, other offsets return 0xFF.
- R10: A direct request of size 0 (byte), 1 (two bytes) or 2/3 (four bytes) runs one byte per cycle at rising addresses, most significant data byte first; `db_done` rises N+1 cycles after the request cycle for N bytes, with read data right-aligned in `db_rdata`.
- R11: In the full model `alarm_hit` pulses for one cycle, one cycle after seconds, minutes, hours and date (masked as in R4 to R6, compared to the time inputs under the same masks) all match while bit 7 of the interrupt enable byte is set.
- R12: After reset the top page reads zero, `db_busy`, `db_done`, `wd_load` and `alarm_hit` are low, and the window address is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 2 | Region hide bits for 0x20..0x2F (bit 0) and 0x30..0x3F (bit 1) |
| db_req | input | 1 | Direct request, taken while `db_busy` is low |
| db_we | input | 1 | Direct request is a write |
| db_size | input | 2 | Byte count code: 0 one, 1 two, 2 or 3 four |
| db_addr | input | ADDR_W | Address of the first byte |
| db_wdata | input | 32 | Write data, right-aligned |
| db_busy | output | 1 | Direct transfer in progress |
| db_done | output | 1 | One-cycle completion pulse |
| db_rdata | output | 32 | Read data, right-aligned, valid with `db_done` |
| pw_sel | input | 1 | Window access this cycle |
| pw_we | input | 1 | Window access is a write |
| pw_off | input | 2 | Window offset |
| pw_wdata | input | 8 | Window write byte |
| pw_rdata | output | 8 | Window read byte (combinational) |
| tm_sec | input | 8 | Current seconds, BCD |
| tm_min | input | 8 | Current minutes, BCD |
| tm_hour | input | 8 | Current hours, BCD |
| tm_date | input | 8 | Current day of month, BCD |
| alarm_hit | output | 1 | One-cycle alarm match pulse |
| wd_load | output | 1 | Watchdog reload strobe |
| wd_value | output | 8 | Byte carried with `wd_load` |

## Verification
A direct transfer of N bytes shows `db_done` and its read data on the (N+1)th falling edge after the request is driven, and the bench counts those edges and checks the count. A watchdog write raises `wd_load` on the same edge that completes the transfer, so the strobe is captured at that moment. Window reads are combinational and are sampled a moment after the offset settles, and window writes take effect at the next rising edge. An alarm match is sampled one falling edge after the time inputs change, and again one edge later to prove the pulse has ended.

// File: rtl/tk_pkg.sv
package tk_pkg;

    localparam int BUS_AW       = 16;
    localparam int ALARM_EN_BIT = 7;

    typedef logic [BUS_AW-1:0] bus_addr_t;

    typedef struct packed {
        logic      valid;
        logic      we;
        bus_addr_t addr;
        logic [7:0] data;
    } byte_op_t;

    typedef enum logic [1:0] {
        XS_BYTE = 2'd0,
        XS_HALF = 2'd1,
        XS_WORD = 2'd2,
        XS_WIDE = 2'd3
    } xfer_size_e;

    typedef enum logic [3:0] {
        RB_FLAGS = 4'h0,
        RB_ASEC  = 4'h2,
        RB_AMIN  = 4'h3,
        RB_AHOUR = 4'h4,
        RB_ADATE = 4'h5,
        RB_IRQEN = 4'h6,
        RB_WDOG  = 4'h7
    } rb_off_e;

    function automatic logic [7:0] alarm_mask(input logic [3:0] off);
        case (rb_off_e'(off))
            RB_AHOUR: return 8'h3F;
            RB_ADATE: return 8'h1F;
            default:  return 8'h7F;
        endcase
    endfunction

    function automatic logic alarm_write_ok(input logic [3:0] off, input logic [7:0] v);
        logic [7:0] m;
        logic [6:0] n;
        logic       ok;
        m  = v & alarm_mask(off);
        ok = (m[7:4] <= 4'd9) && (m[3:0] <= 4'd9);
        n  = 7'(m[7:4]) * 7'd10 + 7'(m[3:0]);
        case (rb_off_e'(off))
            RB_AHOUR: ok = ok && (n <= 7'd23);
            RB_ADATE: ok = ok && (n != 7'd0);
            default:  ok = ok && (n <= 7'd59);
        endcase
        return ok;
    endfunction

    function automatic logic [1:0] last_lane(input logic [1:0] size);
        case (xfer_size_e'(size))
            XS_BYTE: return 2'd0;
            XS_HALF: return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/tk_burst.sv
module tk_burst
    import tk_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [7:0]        core_rdata,
    output byte_op_t          op,
    output logic              busy,
    output logic              done,
    output logic [31:0]       rdata
);

    logic        busy_q, done_q, we_q;
    logic [1:0]  cnt_q, last_q;
    bus_addr_t   base_q;
    logic [31:0] wd_q, acc_q;
    logic [1:0]  lane;
    logic [31:0] lane_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            we_q   <= 1'b0;
            cnt_q  <= '0;
            last_q <= '0;
            base_q <= '0;
            wd_q   <= '0;
            acc_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (req) begin
                    busy_q <= 1'b1;
                    cnt_q  <= '0;
                    last_q <= last_lane(size);
                    base_q <= BUS_AW'(addr);
                    wd_q   <= wdata;
                    we_q   <= we;
                    acc_q  <= '0;
                end
            end else begin
                acc_q <= {acc_q[23:0], core_rdata};
                cnt_q <= cnt_q + 2'd1;
                if (cnt_q == last_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        lane      = last_q - cnt_q;
        lane_bits = wd_q >> {lane, 3'b000};
        op.valid  = busy_q;
        op.we     = we_q;
        op.addr   = base_q + BUS_AW'(cnt_q);
        op.data   = lane_bits[7:0];
    end

    assign busy  = busy_q;
    assign done  = done_q;
    assign rdata = acc_q;

    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q) else $error("done held high"); // R10

endmodule

// File: rtl/tk_port_win.sv
module tk_port_win
    import tk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       grant,
    input  logic       pw_sel,
    input  logic       pw_we,
    input  logic [1:0] pw_off,
    input  logic [7:0] pw_wdata,
    input  logic [7:0] core_rdata,
    output byte_op_t   op,
    output logic [7:0] pw_rdata
);

    bus_addr_t addr_q;
    logic      wr_go;

    assign wr_go = pw_sel && pw_we && grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (wr_go) begin
            case (pw_off)
                2'd0:    addr_q[7:0]  <= pw_wdata;
                2'd1:    addr_q[15:8] <= pw_wdata;
                2'd3:    addr_q       <= '0;
                default: ;
            endcase
        end
    end

    always_comb begin
        op.valid = wr_go && (pw_off == 2'd3);
        op.we    = 1'b1;
        op.addr  = addr_q;
        op.data  = pw_wdata;
        pw_rdata = (grant && pw_off == 2'd3) ? core_rdata : 8'hFF;
    end

    AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_go && pw_off == 2'd3) |=> (addr_q == '0)) else $error("address not cleared"); // R9

endmodule

// File: rtl/tk_store.sv
module tk_store
    import tk_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int LOW_BYTES  = 128,
    parameter bit FULL_MODEL = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] lock_i,
    input  byte_op_t   op,
    input  logic [7:0] tm_sec,
    input  logic [7:0] tm_min,
    input  logic [7:0] tm_hour,
    input  logic [7:0] tm_date,
    output logic [7:0] rdata,
    output logic       alarm_hit,
    output logic       wd_load,
    output logic [7:0] wd_value
);

    localparam int PAGE_W = ADDR_W - 4;
    localparam int LOW_AW = $clog2(LOW_BYTES);
    localparam int TOP_N  = 16;
    localparam logic [ADDR_W:0] LOW_LIM    = (ADDR_W+1)'(LOW_BYTES);
    localparam logic [PAGE_W-1:0] LOCK0_PG = PAGE_W'(2);
    localparam logic [PAGE_W-1:0] LOCK1_PG = PAGE_W'(3);

    logic [7:0] low_mem [LOW_BYTES];
    logic [7:0] top_reg [TOP_N];

    logic [ADDR_W-1:0] a;
    logic [3:0]        off;
    logic [LOW_AW-1:0] idx;
    logic              hi_zero, in_low, in_top, locked, top_accept, wr;

    always_comb begin
        a       = op.addr[ADDR_W-1:0];
        off     = a[3:0];
        idx     = a[LOW_AW-1:0];
        hi_zero = (op.addr >> ADDR_W) == '0;
        in_low  = hi_zero && ({1'b0, a} < LOW_LIM);
        in_top  = hi_zero && (a[ADDR_W-1:4] == '1);
        locked  = in_low && ((lock_i[0] && a[ADDR_W-1:4] == LOCK0_PG) ||
                             (lock_i[1] && a[ADDR_W-1:4] == LOCK1_PG));
        wr      = op.valid && op.we;
        if (locked)      rdata = 8'hFF;
        else if (in_low) rdata = low_mem[idx];
        else if (in_top) rdata = top_reg[off];
        else             rdata = 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (wr && in_low && !locked) low_mem[idx] <= op.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TOP_N; i++) top_reg[i] <= '0;
        end else if (wr && in_top && top_accept) begin
            top_reg[off] <= op.data;
        end
    end

    generate
        if (FULL_MODEL) begin : gen_full
            logic match_now, match_q;

            always_comb begin
                case (rb_off_e'(off))
                    RB_FLAGS: top_accept = 1'b0;
                    RB_ASEC, RB_AMIN, RB_AHOUR, RB_ADATE:
                              top_accept = alarm_write_ok(off, op.data);
                    default:  top_accept = 1'b1;
                endcase
                match_now = top_reg[RB_IRQEN][ALARM_EN_BIT] &&
                    ((top_reg[RB_ASEC]  & 8'h7F) == (tm_sec  & 8'h7F)) &&
                    ((top_reg[RB_AMIN]  & 8'h7F) == (tm_min  & 8'h7F)) &&
                    ((top_reg[RB_AHOUR] & 8'h3F) == (tm_hour & 8'h3F)) &&
                    ((top_reg[RB_ADATE] & 8'h1F) == (tm_date & 8'h1F));
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    match_q   <= 1'b0;
                    alarm_hit <= 1'b0;
                    wd_load   <= 1'b0;
                    wd_value  <= '0;
                end else begin
                    match_q   <= match_now;
                    alarm_hit <= match_now && !match_q;
                    wd_load   <= wr && in_top && (off == RB_WDOG);
                    if (wr && in_top && (off == RB_WDOG)) wd_value <= op.data;
                end
            end

            AST_FLAGS_RO: assert property (@(posedge clk) disable iff (rst)
                $stable(top_reg[RB_FLAGS])) else $error("flags changed"); // R3
            AST_ASEC_BCD: assert property (@(posedge clk) disable iff (rst)
                alarm_write_ok(RB_ASEC, top_reg[RB_ASEC])) else $error("bad seconds stored"); // R4
            AST_AHOUR_BCD: assert property (@(posedge clk) disable iff (rst)
                alarm_write_ok(RB_AHOUR, top_reg[RB_AHOUR])) else $error("bad hours stored"); // R5
            AST_HIT_ONE: assert property (@(posedge clk) disable iff (rst)
                alarm_hit |=> !alarm_hit) else $error("alarm pulse too long"); // R11
        end else begin : gen_basic
            assign top_accept = 1'b1;
            assign alarm_hit  = 1'b0;
            assign wd_load    = 1'b0;
            assign wd_value   = 8'h00;
        end
    endgenerate

    AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (rst)
        (wr && locked) |=> (low_mem[$past(idx)] == $past(low_mem[idx]))) else $error("locked byte written"); // R2

endmodule

// File: rtl/tk_nvram.sv
module tk_nvram
    import tk_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int LOW_BYTES  = 128,
    parameter bit FULL_MODEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        lock_i,
    input  logic              db_req,
    input  logic              db_we,
    input  logic [1:0]        db_size,
    input  logic [ADDR_W-1:0] db_addr,
    input  logic [31:0]       db_wdata,
    output logic              db_busy,
    output logic              db_done,
    output logic [31:0]       db_rdata,
    input  logic              pw_sel,
    input  logic              pw_we,
    input  logic [1:0]        pw_off,
    input  logic [7:0]        pw_wdata,
    output logic [7:0]        pw_rdata,
    input  logic [7:0]        tm_sec,
    input  logic [7:0]        tm_min,
    input  logic [7:0]        tm_hour,
    input  logic [7:0]        tm_date,
    output logic              alarm_hit,
    output logic              wd_load,
    output logic [7:0]        wd_value
);

    byte_op_t   burst_op, win_op, core_op;
    logic [7:0] core_rdata;

    tk_burst #(.ADDR_W(ADDR_W)) burst_i (
        .clk(clk), .rst(rst), .req(db_req), .we(db_we), .size(db_size),
        .addr(db_addr), .wdata(db_wdata), .core_rdata(core_rdata),
        .op(burst_op), .busy(db_busy), .done(db_done), .rdata(db_rdata)
    );

    tk_port_win win_i (
        .clk(clk), .rst(rst), .grant(!db_busy), .pw_sel(pw_sel), .pw_we(pw_we),
        .pw_off(pw_off), .pw_wdata(pw_wdata), .core_rdata(core_rdata),
        .op(win_op), .pw_rdata(pw_rdata)
    );

    assign core_op = db_busy ? burst_op : win_op;

    tk_store #(.ADDR_W(ADDR_W), .LOW_BYTES(LOW_BYTES), .FULL_MODEL(FULL_MODEL)) store_i (
        .clk(clk), .rst(rst), .lock_i(lock_i), .op(core_op),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_date(tm_date),
        .rdata(core_rdata), .alarm_hit(alarm_hit), .wd_load(wd_load), .wd_value(wd_value)
    );

endmodule

// File: tb/tk_nvram_tb_top.sv
module tk_nvram_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 13;
    localparam int LOW_BYTES  = 128;
    localparam int WD_LIMIT   = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] lock_i = 2'b00;
    logic db_req = 1'b0, db_we = 1'b0;
    logic [1:0] db_size = 2'd0;
    logic [ADDR_W-1:0] db_addr = '0;
    logic [31:0] db_wdata = '0;
    logic pw_sel = 1'b0, pw_we = 1'b0;
    logic [1:0] pw_off = 2'd0;
    logic [7:0] pw_wdata = '0;
    logic [7:0] tm_sec = '0, tm_min = '0, tm_hour = '0, tm_date = '0;

    logic f_busy, f_done, f_hit, f_wdl, b_busy, b_done, b_hit, b_wdl;
    logic [31:0] f_rd, b_rd;
    logic [7:0] f_pw, b_pw, f_wdv, b_wdv;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tk_nvram #(.ADDR_W(ADDR_W), .LOW_BYTES(LOW_BYTES), .FULL_MODEL(1'b1)) dut_i (
        .clk(clk), .rst(rst), .lock_i(lock_i), .db_req(db_req), .db_we(db_we),
        .db_size(db_size), .db_addr(db_addr), .db_wdata(db_wdata), .db_busy(f_busy),
        .db_done(f_done), .db_rdata(f_rd), .pw_sel(pw_sel), .pw_we(pw_we),
        .pw_off(pw_off), .pw_wdata(pw_wdata), .pw_rdata(f_pw), .tm_sec(tm_sec),
        .tm_min(tm_min), .tm_hour(tm_hour), .tm_date(tm_date), .alarm_hit(f_hit),
        .wd_load(f_wdl), .wd_value(f_wdv)
    );

    tk_nvram #(.ADDR_W(ADDR_W), .LOW_BYTES(LOW_BYTES), .FULL_MODEL(1'b0)) dut_basic_i (
        .clk(clk), .rst(rst), .lock_i(lock_i), .db_req(db_req), .db_we(db_we),
        .db_size(db_size), .db_addr(db_addr), .db_wdata(db_wdata), .db_busy(b_busy),
        .db_done(b_done), .db_rdata(b_rd), .pw_sel(pw_sel), .pw_we(pw_we),
        .pw_off(pw_off), .pw_wdata(pw_wdata), .pw_rdata(b_pw), .tm_sec(tm_sec),
        .tm_min(tm_min), .tm_hour(tm_hour), .tm_date(tm_date), .alarm_hit(b_hit),
        .wd_load(b_wdl), .wd_value(b_wdv)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(negedge clk) begin
        cycles++;
        if (cycles == WD_LIMIT) begin
            bad++;
            $display("FAIL watchdog got=%0d exp=done", cycles);
            summary();
        end
    end

    // reference for R4/R5/R6: keep the write when masked BCD is in range
    function automatic bit ref_ok(input int k, input int v);
        int m, hi, lo, n;
        m  = (k == 4) ? (v & 'h3F) : (k == 5) ? (v & 'h1F) : (v & 'h7F);
        hi = m / 16;
        lo = m % 16;
        if (hi > 9 || lo > 9) return 1'b0;
        n = hi * 10 + lo;
        if (k == 4) return n <= 23;
        if (k == 5) return n != 0;
        return n <= 59;
    endfunction

    logic [31:0] rf, rb;
    logic        wf, wb;
    logic [7:0]  vf;

    // direct transfer; also checks done timing (R10)
    task automatic xfer(input logic we, input logic [1:0] sz, input int addr, input logic [31:0] wd);
        int n, k;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        @(negedge clk);
        db_req = 1'b1; db_we = we; db_size = sz; db_addr = ADDR_W'(addr); db_wdata = wd;
        @(negedge clk);
        db_req = 1'b0;
        k = 1;
        while (!f_done && k < 10) begin
            @(negedge clk);
            k++;
        end
        check("R10 done latency", 32'(k), 32'(n + 1));
        check("R10 basic done", {31'b0, b_done}, 32'd1);
        rf = f_rd; rb = b_rd; wf = f_wdl; wb = b_wdl; vf = f_wdv;
    endtask

    task automatic pw_write(input logic [1:0] off, input logic [7:0] d);
        @(negedge clk);
        pw_sel = 1'b1; pw_we = 1'b1; pw_off = off; pw_wdata = d;
        @(negedge clk);
        pw_sel = 1'b0; pw_we = 1'b0;
    endtask

    task automatic pw_read(input logic [1:0] off);
        @(negedge clk);
        pw_sel = 1'b1; pw_we = 1'b0; pw_off = off;
        #1;
        rf = {24'h0, f_pw}; rb = {24'h0, b_pw};
        @(negedge clk);
        pw_sel = 1'b0;
    endtask

    logic [7:0] exp_low [LOW_BYTES];
    logic [7:0] exp_alarm [2:5];

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        check("R12 busy", {30'b0, f_busy, b_busy}, 32'd0);
        check("R12 strobes", {28'b0, f_hit, f_wdl, b_hit, b_wdl}, 32'd0);
        for (int k = 0; k < 8; k++) begin
            xfer(1'b0, 2'd0, 'h1FF0 + k, 0);
            check("R12 top page full", rf, 0);
            check("R12 top page basic", rb, 0);
        end
        xfer(1'b0, 2'd0, 0, 0);
        pw_write(2'd3, 8'h6B);
        xfer(1'b0, 2'd0, 0, 0);
        check("R12 window address zero", rf, 32'h6B);

        // R1 outside storage
        xfer(1'b1, 2'd0, 'h1000, 32'h12);
        xfer(1'b0, 2'd0, 'h1000, 0);
        check("R1 hole read full", rf, 32'hFF);
        check("R1 hole read basic", rb, 32'hFF);
        xfer(1'b0, 2'd0, LOW_BYTES, 0);
        check("R1 first byte past low array", rf, 32'hFF);
        pw_write(2'd0, 8'h00); pw_write(2'd1, 8'h80);
        pw_read(2'd3);
        check("R1 high address bits", rf, 32'hFF);
        pw_write(2'd0, 8'h00); pw_write(2'd1, 8'h00);

        // R10 big-endian splitting
        xfer(1'b1, 2'd2, 'h40, 32'hA1B2C3D4);
        for (int k = 0; k < 4; k++) begin
            xfer(1'b0, 2'd0, 'h40 + k, 0);
            check("R10 word byte order", rf, 32'((32'hA1B2C3D4 >> (8 * (3 - k))) & 32'hFF));
        end
        xfer(1'b0, 2'd1, 'h42, 0);
        check("R10 half read", rf, 32'hC3D4);
        xfer(1'b0, 2'd3, 'h40, 0);
        check("R10 word read", rf, 32'hA1B2C3D4);
        xfer(1'b1, 2'd1, 'h44, 32'h0000_5566);
        xfer(1'b0, 2'd0, 'h44, 0);
        check("R10 half write msb", rf, 32'h55);
        xfer(1'b0, 2'd0, 'h45, 0);
        check("R10 half write lsb", rf, 32'h66);

        // R2 lock windows
        for (int a = 'h18; a < 'h48; a++) begin
            exp_low[a] = 8'(a ^ 'h5A);
            xfer(1'b1, 2'd0, a, 32'(a ^ 'h5A));
        end
        for (int lk = 0; lk < 4; lk++) begin
            lock_i = 2'(lk);
            for (int a = 'h18; a < 'h48; a++) begin
                bit hid;
                hid = (lk[0] && a >= 'h20 && a <= 'h2F) || (lk[1] && a >= 'h30 && a <= 'h3F);
                xfer(1'b0, 2'd0, a, 0);
                check("R2 locked read", rf, hid ? 32'hFF : 32'(exp_low[a]));
                xfer(1'b1, 2'd0, a, 32'(~exp_low[a] & 8'hFF) + 32'(lk));
                if (!hid) exp_low[a] = 8'(32'(~exp_low[a] & 8'hFF) + 32'(lk));
            end
            lock_i = 2'b00;
            for (int a = 'h18; a < 'h48; a++) begin
                xfer(1'b0, 2'd0, a, 0);
                check("R2 contents after lock", rf, 32'(exp_low[a]));
                check("R2 contents basic", rb, 32'(exp_low[a]));
            end
        end

        // R3 flags read-only
        xfer(1'b1, 2'd0, 'h1FF0, 32'h77);
        xfer(1'b0, 2'd0, 'h1FF0, 0);
        check("R3 flags full", rf, 32'h00);
        check("R8 flags basic", rb, 32'h77);

        // R4 R5 R6 R8 exhaustive alarm sweeps
        for (int k = 2; k <= 5; k++) exp_alarm[k] = 8'h00;
        for (int k = 2; k <= 5; k++) begin
            for (int v = 0; v < 256; v++) begin
                xfer(1'b1, 2'd0, 'h1FF0 + k, 32'(v));
                if (ref_ok(k, v)) exp_alarm[k] = 8'(v);
                xfer(1'b0, 2'd0, 'h1FF0 + k, 0);
                if (k <= 3)      check("R4 alarm sec/min filter", rf, 32'(exp_alarm[k]));
                else if (k == 4) check("R5 alarm hour filter", rf, 32'(exp_alarm[k]));
                else             check("R6 alarm date filter", rf, 32'(exp_alarm[k]));
                check("R8 basic plain byte", rb, 32'(v));
            end
        end

        // R7 interrupt and watchdog bytes
        xfer(1'b1, 2'd0, 'h1FF6, 32'h3E);
        xfer(1'b0, 2'd0, 'h1FF6, 0);
        check("R7 irq enable stored", rf, 32'h3E);
        xfer(1'b1, 2'd0, 'h1FF7, 32'h9C);
        check("R7 wd strobe", {31'b0, wf}, 32'd1);
        check("R7 wd value", {24'b0, vf}, 32'h9C);
        check("R8 basic no wd strobe", {31'b0, wb}, 32'd0);
        @(negedge clk);
        check("R7 wd strobe one cycle", {31'b0, f_wdl}, 32'd0);
        xfer(1'b0, 2'd0, 'h1FF7, 0);
        check("R7 wd stored", rf, 32'h9C);
        check("R7 wd basic stored", rb, 32'h9C);

        // R9 indirect window
        pw_write(2'd0, 8'h45); pw_write(2'd1, 8'h00);
        pw_write(2'd3, 8'hE7);
        xfer(1'b0, 2'd0, 'h45, 0);
        check("R9 window write", rf, 32'hE7);
        pw_write(2'd3, 8'h11);
        xfer(1'b0, 2'd0, 0, 0);
        check("R9 address cleared", rf, 32'h11);
        pw_write(2'd0, 8'hF7); pw_write(2'd1, 8'h1F);
        pw_write(2'd2, 8'hAA);
        pw_read(2'd3);
        check("R9 window read", rf, 32'h9C);
        check("R9 window read basic", rb, 32'h9C);
        for (int o = 0; o < 3; o++) begin
            pw_read(2'(o));
            check("R9 other offsets", rf, 32'hFF);
        end
        pw_write(2'd0, 8'hF2);
        pw_write(2'd3, 8'h60);
        xfer(1'b0, 2'd0, 'h1FF2, 0);
        check("R4 window write filtered", rf, 32'(exp_alarm[2]));
        check("R8 window write basic", rb, 32'h60);

        // R11 alarm match
        tm_sec = 8'h29; tm_min = 8'h15; tm_hour = 8'h08; tm_date = 8'h12;
        xfer(1'b1, 2'd2, 'h1FF2, 32'h30150812);
        xfer(1'b1, 2'd0, 'h1FF6, 32'h80);
        @(negedge clk);
        check("R11 no match", {30'b0, f_hit, b_hit}, 32'd0);
        tm_sec = 8'h30;
        @(negedge clk);
        check("R11 hit pulse", {31'b0, f_hit}, 32'd1);
        check("R8 basic no hit", {31'b0, b_hit}, 32'd0);
        @(negedge clk);
        check("R11 pulse ends", {31'b0, f_hit}, 32'd0);
        tm_hour = 8'hC8;
        @(negedge clk);
        check("R11 masked hour ignored", {31'b0, f_hit}, 32'd0);
        tm_sec = 8'h31;
        @(negedge clk);
        tm_sec = 8'hB0;
        @(negedge clk);
        check("R11 masked re-match", {31'b0, f_hit}, 32'd1);
        xfer(1'b1, 2'd0, 'h1FF6, 32'h00);
        tm_sec = 8'h31;
        @(negedge clk);
        tm_sec = 8'h30;
        @(negedge clk);
        check("R11 disabled", {31'b0, f_hit}, 32'd0);

        summary();
    end

endmodule